// File: doc/BRIEF.md
# Hysteresis Threshold Alert Comparator

This block watches a stream of 10-bit converter readings and raises a single alert flag when a reading moves past a programmable limit. Each reading arrives as a 16-bit word with the measured value left-aligned in the upper ten bits and a one-cycle valid strobe. The low six bits of the word are ignored. The limit is a 10-bit threshold. It is widened by a 7-bit hysteresis band, so the flag sets on one side of the band and clears only on the other side, and noise around the limit does not toggle it.

The sense direction is fixed when the block is built. An over-limit instance alerts on high readings and an under-limit instance alerts on low readings. Software programs the threshold and the hysteresis through a small write port with a register select, and can read the selected register back. An all-ones threshold turns detection off.

Top module: `hyst_alert_cmp`

## Requirements
- R1: After reset the alert is 0, the threshold register reads FFFFh and the hysteresis register reads 000Ah.
- R2: A write with reg_sel=0 stores wdata bits 15..6 as the threshold. A read with reg_sel=0 returns the threshold in bits 15..6 and ones in bits 5..0. Without reg_wr, the registers keep their values.
- R3: A write with reg_sel=1 stores wdata bits 6..0 as the hysteresis. A read with reg_sel=1 returns it in bits 6..0 and zeros in bits 15..7.
- R4: Only sample bits 15..6 form the compared value; bits 5..0 have no effect on the alert.
- R5: In over-limit sense, a valid sample above the upper bound (threshold plus hysteresis) sets the alert on the next clock.
- R6: In over-limit sense, a valid sample below the lower bound (threshold minus hysteresis) clears the alert. A sample from the lower bound to the upper bound, inclusive, leaves the alert unchanged.
- R7: In under-limit sense, a valid sample below the lower bound sets the alert, a valid sample above the upper bound clears it, and a sample between the bounds leaves it unchanged.
- R8: The upper bound saturates at 1023 and the lower bound saturates at 0; neither wraps.
- R9: The alert changes only on a clock where sample_valid is 1, except for the disable case of R10.
- R10: While the stored threshold is 1023, the alert is 0 on the next clock, whatever the samples are. This includes the case where the alert was active when the value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 threshold, 1 hysteresis |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sample_valid | input | 1 | Sample strobe |
| sample_word | input | 16 | Sample word, value in bits 15..6 |
| alert | output | 1 | Registered alert flag |

## Verification
The bench builds two instances side by side with the default widths: one with OVER_SENSE=1 and one with OVER_SENSE=0. Both receive the same register writes and samples, so each sample checks both sense directions and their opposite set and clear rules against one bench model. Directed thresholds near 0 and near 1023 push the bounds into saturation, where a wrapping sum or difference would flip the alert. Random thresholds, mostly near mid-scale with an occasional 1023, exercise the hold band and the disable path.

// File: rtl/hyst_alert_cmp.sv
module hyst_alert_cmp #(
  parameter int WORD_W     = 16,
  parameter int VAL_W      = 10,
  parameter int HYS_W      = 7,
  parameter int HYS_RST    = 10,
  parameter bit OVER_SENSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              sample_valid,
  input  logic [WORD_W-1:0] sample_word,
  output logic              alert
);
  localparam int LOW_W = WORD_W - VAL_W;
  localparam logic [VAL_W-1:0] VMAX = '1;

  logic [VAL_W-1:0] thr_q;
  logic [HYS_W-1:0] hys_q;
  logic             alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= VMAX;
      hys_q <= HYS_W'(HYS_RST);
    end else if (reg_wr) begin
      if (reg_sel) hys_q <= reg_wdata[HYS_W-1:0];
      else         thr_q <= reg_wdata[WORD_W-1:LOW_W];
    end
  end

  assign reg_rdata = reg_sel ? {{(WORD_W-HYS_W){1'b0}}, hys_q}
                             : {thr_q, {LOW_W{1'b1}}};

  logic [VAL_W:0]   sum_w, dif_w;
  logic [VAL_W-1:0] upper, lower, smp;
  logic             disabled, above, below, set_c, clr_c;

  assign sum_w = {1'b0, thr_q} + (VAL_W+1)'(hys_q);
  assign dif_w = {1'b0, thr_q} - (VAL_W+1)'(hys_q);
  assign upper = sum_w[VAL_W] ? VMAX : sum_w[VAL_W-1:0];
  assign lower = dif_w[VAL_W] ? '0   : dif_w[VAL_W-1:0];
  assign smp   = sample_word[WORD_W-1:LOW_W];
  assign disabled = (thr_q == VMAX);
  assign above = smp > upper;
  assign below = smp < lower;

  generate
    if (OVER_SENSE) begin : g_over
      assign set_c = above;
      assign clr_c = below;
    end else begin : g_under
      assign set_c = below;
      assign clr_c = above;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            alert_q <= 1'b0;
    else if (disabled)     alert_q <= 1'b0;
    else if (sample_valid) begin
      if (set_c)      alert_q <= 1'b1;
      else if (clr_c) alert_q <= 1'b0;
    end
  end

  assign alert = alert_q;

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !alert);
  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !disabled) |=> $stable(alert));
  assert_rise_needs_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> ($past(sample_valid) && $past(set_c)));
  assert_fall_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert) |-> ($past(disabled) || ($past(sample_valid) && $past(clr_c))));
  assert_bounds_ordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lower <= thr_q) && (upper >= thr_q));
endmodule

// File: tb/tb_hyst_alert_cmp.sv
module tb_hyst_alert_cmp;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0, sample_valid = 0;
  logic [15:0] reg_wdata = '0, sample_word = '0;
  logic [15:0] rd_o, rd_u;
  logic al_o, al_u;
  int checks = 0, errors = 0;
  int m_thr = 1023, m_hys = 10;
  bit m_o = 0, m_u = 0;

  always #4 clk = ~clk;

  hyst_alert_cmp #(.OVER_SENSE(1'b1)) dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd_o),
    .sample_valid(sample_valid), .sample_word(sample_word), .alert(al_o));
  hyst_alert_cmp #(.OVER_SENSE(1'b0)) dut_u (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rd_u),
    .sample_valid(sample_valid), .sample_word(sample_word), .alert(al_u));

  function automatic bit nxt(bit prev, int s, int thr, int hys, bit over, bit vld);
    int up, lo;
    up = (thr + hys > 1023) ? 1023 : thr + hys;
    lo = (thr - hys < 0) ? 0 : thr - hys;
    if (thr == 1023) return 1'b0;
    if (!vld) return prev;
    if (over) begin
      if (s > up) return 1'b1;
      if (s < lo) return 1'b0;
    end else begin
      if (s < lo) return 1'b1;
      if (s > up) return 1'b0;
    end
    return prev;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit wr, bit sel, logic [15:0] wd, bit vld, logic [15:0] sw, string req);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; sample_valid = vld; sample_word = sw;
    m_o = nxt(m_o, int'(sw[15:6]), m_thr, m_hys, 1'b1, vld);
    m_u = nxt(m_u, int'(sw[15:6]), m_thr, m_hys, 1'b0, vld);
    if (wr) begin
      if (sel) m_hys = int'(wd[6:0]);
      else     m_thr = int'(wd[15:6]);
    end
    @(posedge clk); #1;
    chk({req, " over"}, al_o, m_o);
    chk({req, " under"}, al_u, m_u);
    reg_wr = 0; sample_valid = 0;
  endtask

  function automatic logic [15:0] sv(int v, int lo6);
    return {v[9:0], lo6[5:0]};
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 alert", al_o, 0);
    chk("R1 alert", al_u, 0);
    reg_sel = 0; #1; chk("R1 thr read", rd_o, 16'hFFFF);
    reg_sel = 1; #1; chk("R1 hys read", rd_o, 16'h000A);
    @(negedge clk); rst_n = 1;
    // R10: reset threshold is 1023, so extreme samples leave alert low
    step(0, 0, 0, 1, sv(1023, 0), "R10");
    step(0, 0, 0, 1, sv(0, 0), "R10");
    // R2 / R3 write and readback
    step(1, 0, 16'h8000 | 16'h0015, 0, 0, "R2");
    reg_sel = 0; #1; chk("R2 thr read", rd_o, 16'h803F);
    step(1, 1, 16'hFFA5, 0, 0, "R3");
    reg_sel = 1; #1; chk("R3 hys read", rd_u, 16'h0025);
    step(0, 1, 16'h1234, 0, 0, "R2");
    reg_sel = 1; #1; chk("R2 no write", rd_o, 16'h0025);
    // threshold 512, hysteresis 37: bounds 475..549
    step(1, 1, 16'd37, 0, 0, "R3");
    step(0, 0, 0, 1, sv(549, 63), "R6 hold at upper");
    step(0, 0, 0, 1, sv(550, 0), "R5 set above");
    step(0, 0, 0, 0, sv(10, 0), "R9 no strobe");
    step(0, 0, 0, 1, sv(475, 0), "R6 hold at lower");
    step(0, 0, 0, 1, sv(474, 0), "R6 R7 below");
    step(0, 0, 0, 1, sv(520, 63), "R4 R7 hold");
    step(0, 0, 0, 1, sv(600, 0), "R7 clear above");
    step(0, 0, 0, 1, sv(549, 63), "R4 low bits ignored");
    // R10: disable while over alert active
    step(0, 0, 0, 1, sv(700, 0), "R5");
    step(1, 0, 16'hFFC0, 0, 0, "R10 write disable");
    step(0, 0, 0, 0, 0, "R10 cleared");
    // R8 saturation: thr 1020 hys 10, upper 1023
    step(1, 1, 16'd10, 0, 0, "R8");
    step(1, 0, sv(1020, 0), 0, 0, "R8");
    step(0, 0, 0, 1, sv(1015, 0), "R8 upper saturates");
    step(0, 0, 0, 1, sv(1023, 0), "R8 top");
    // R8: thr 3, lower 0
    step(1, 0, sv(3, 0), 0, 0, "R8");
    step(0, 0, 0, 1, sv(500, 0), "R8 lower saturates");
    step(0, 0, 0, 1, sv(0, 0), "R8 bottom");
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) step(1, 0, sv(($urandom_range(0, 15) == 0) ? 1023 : $urandom_range(400, 620),
                               $urandom_range(0, 63)), $urandom_range(0, 1),
                       sv($urandom_range(300, 720), $urandom_range(0, 63)), "R2 R10 rand");
      else if (r == 1) step(1, 1, 16'($urandom_range(0, 65535)), $urandom_range(0, 1),
                            sv($urandom_range(300, 720), 0), "R3 rand");
      else step(0, $urandom_range(0, 1), 0, $urandom_range(0, 3) != 0,
                sv($urandom_range(300, 720), $urandom_range(0, 63)), "R5 R6 R7 R9 rand");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule